// File: doc/BRIEF.md
# Column-Parallel 2x2 Cluster Finder

The block takes one row of small pixel amplitudes per accepted transfer. All columns arrive side by side, one 5-bit sample per column. It keeps the previously accepted row in a line buffer. Over every pair of neighbouring columns it adds the two current samples and the two samples held from the prior row. Each column pair whose 4-sample sum reaches a programmable threshold becomes a hit.

Hits are serialised into sparse records, one per clock, in ascending column order. The records pass into an output FIFO that the consumer drains with a valid/ready handshake. While a row's hits are being serialised, the block holds off the next row. When the FIFO is full, further records are discarded and counted in a saturating drop counter.

Top module: `cluster_finder_2x2`

## Requirements
- R1: A row accepted with `row_first` high, or the first row accepted after reset, produces no records. Its samples are still stored as the prior row for the next kernel.
- R2: For left column c (0 to 123), the kernel sum is cur[c] + cur[c+1] + prior[c] + prior[c+1], computed as a 7-bit value. The position is a hit when this sum is greater than or equal to the threshold.
- R3: `out_data` is 24 bits. Bits [23:14] hold the row number, bits [13:7] hold the left column index, and bits [6:0] hold the kernel sum.
- R4: Records of one row are written to the FIFO one per cycle, in ascending column order. `row_ready` is low for exactly as many cycles as the row has hits, starting the cycle after acceptance.
- R5: The threshold register resets to 127, so no position is a hit. A write with `thr_we` high takes effect for rows accepted on later edges.
- R6: A record produced while the FIFO holds 16 entries is discarded, and `ovf_count` increases by one. The counter saturates at all ones and otherwise never changes.
- R7: The FIFO is first-word-fall-through. `out_valid` is high whenever it holds a record, and an entry is removed on each edge where `out_valid` and `out_ready` are both high.
- R8: The row number is 0 for a row accepted with `row_first` high and increases by one per accepted row otherwise, wrapping from 1023 to 0.
- R9: `row_valid` is ignored while `row_ready` is low. Such a row does not change the prior row, the row number or the records.
- R10: After reset, `row_ready` is high, `out_valid` is low and `ovf_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 7 | New threshold value |
| row_valid | input | 1 | A row is offered on `row_data` |
| row_first | input | 1 | Offered row starts a new frame |
| row_data | input | 625 | 125 samples of 5 bits; column c at bits [5c+4:5c] |
| row_ready | output | 1 | Block can accept a row this cycle |
| out_valid | output | 1 | FIFO holds a record |
| out_ready | input | 1 | Consumer removes the head record |
| out_data | output | 24 | Head record {row, column, sum} |
| ovf_count | output | 16 | Number of discarded records, saturating |

## Verification
A row is accepted on edge E0. Its k-th hit is written to the FIFO on edge E0+k, so `row_ready` reads low on exactly k falling edges before rising again. The bench samples on falling edges only and counts those low cycles against the hit count of its own arithmetic model. It drains the FIFO only after `row_ready` returns, so the kept records are the first 16 the model predicts. The drop counter is compared after every row. Thresholds are swept across the full sum range over patterned rows, with a saturated row, a frame restart, an ignored offer during a busy row and a row-number wrap.

// File: rtl/cf_pkg.sv
package cf_pkg;

    localparam int CF_NCOL       = 125;
    localparam int CF_AW         = 5;
    localparam int CF_SW         = CF_AW + 2;
    localparam int CF_NK         = CF_NCOL - 1;
    localparam int CF_CW         = $clog2(CF_NCOL);
    localparam int CF_ROWW       = 10;
    localparam int CF_RECW       = CF_ROWW + CF_CW + CF_SW;
    localparam int CF_FIFO_DEPTH = 16;

    typedef struct packed {
        logic [CF_ROWW-1:0] row;
        logic [CF_CW-1:0]   col;
        logic [CF_SW-1:0]   sum;
    } cf_rec_t;

    typedef enum logic [0:0] {
        ENC_IDLE  = 1'b0,
        ENC_DRAIN = 1'b1
    } cf_enc_e;

    function automatic logic [CF_SW-1:0] cf_sum4(
        input logic [CF_AW-1:0] a,
        input logic [CF_AW-1:0] b,
        input logic [CF_AW-1:0] c,
        input logic [CF_AW-1:0] d
    );
        return CF_SW'(a) + CF_SW'(b) + CF_SW'(c) + CF_SW'(d);
    endfunction

    function automatic logic [CF_CW-1:0] cf_lowest(input logic [CF_NK-1:0] m);
        logic [CF_CW-1:0] r;
        r = '0;
        for (int i = CF_NK - 1; i >= 0; i--) begin
            if (m[i]) r = CF_CW'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/cf_kernel_array.sv
module cf_kernel_array
    import cf_pkg::*;
(
    input  logic [CF_NCOL*CF_AW-1:0] cur_row,
    input  logic [CF_NCOL*CF_AW-1:0] prev_row,
    input  logic [CF_SW-1:0]         thr,
    input  logic                     en,
    output logic [CF_NK*CF_SW-1:0]   sums,
    output logic [CF_NK-1:0]         hits
);

    for (genvar c = 0; c < CF_NK; c++) begin : g_kern
        logic [CF_SW-1:0] s;
        assign s = cf_sum4(cur_row[c*CF_AW +: CF_AW],
                           cur_row[(c+1)*CF_AW +: CF_AW],
                           prev_row[c*CF_AW +: CF_AW],
                           prev_row[(c+1)*CF_AW +: CF_AW]);
        assign sums[c*CF_SW +: CF_SW] = s;
        assign hits[c] = en && (s >= thr);
    end

endmodule

// File: rtl/cf_sparse_enc.sv
module cf_sparse_enc
    import cf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [CF_NK-1:0]       hits_in,
    input  logic [CF_NK*CF_SW-1:0] sums_in,
    input  logic [CF_ROWW-1:0]     row_in,
    output logic                   idle,
    output logic                   push,
    output cf_rec_t                rec
);

    cf_enc_e                st_q;
    logic [CF_NK-1:0]       mask_q;
    logic [CF_NK-1:0]       mask_nx;
    logic [CF_NK*CF_SW-1:0] sums_q;
    logic [CF_ROWW-1:0]     row_q;
    logic [CF_CW-1:0]       idx;

    assign idx     = cf_lowest(mask_q);
    assign mask_nx = mask_q & (mask_q - CF_NK'(1));
    assign idle    = (st_q == ENC_IDLE);
    assign push    = (st_q == ENC_DRAIN) && (mask_q != '0);

    always_comb begin
        rec.row = row_q;
        rec.col = idx;
        rec.sum = sums_q[idx*CF_SW +: CF_SW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ENC_IDLE;
            mask_q <= '0;
            sums_q <= '0;
            row_q  <= '0;
        end else if (load) begin
            mask_q <= hits_in;
            sums_q <= sums_in;
            row_q  <= row_in;
            st_q   <= (hits_in != '0) ? ENC_DRAIN : ENC_IDLE;
        end else if (st_q == ENC_DRAIN) begin
            mask_q <= mask_nx;
            if (mask_nx == '0) st_q <= ENC_IDLE;
        end
    end

    // R4: each draining cycle retires exactly one pending hit
    p_one_hit_per_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ENC_DRAIN) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));

    // R4: back-to-back records of a row leave in ascending column order
    p_col_ascending_r4: assert property (@(posedge clk) disable iff (rst)
        (push && $past(push)) |-> (rec.col > $past(rec.col)));

    // R4: idle state never holds pending hits
    p_idle_empty_r4: assert property (@(posedge clk) disable iff (rst)
        idle |-> (mask_q == '0));

endmodule

// File: rtl/cf_fifo.sv
module cf_fifo
    import cf_pkg::*;
#(
    parameter int DEPTH = CF_FIFO_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  cf_rec_t       wr_data,
    output logic          full,
    input  logic          rd_en,
    output cf_rec_t       rd_data,
    output logic          empty
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    cf_rec_t         mem [DEPTH];
    logic [PW-1:0]   wp_q;
    logic [PW-1:0]   rp_q;
    logic [CW-1:0]   cnt_q;
    logic            do_wr;
    logic            do_rd;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wp_q <= wp_q + PW'(1);
            if (do_rd) rp_q <= rp_q + PW'(1);
            case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R6: a write into a full FIFO without a read leaves it full and unchanged
    p_full_write_dropped_r6: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> (full && $stable(wp_q)));

    // R7: removing the last entry empties the FIFO
    p_last_pop_empties_r7: assert property (@(posedge clk) disable iff (rst)
        ((cnt_q == CW'(1)) && rd_en && !wr_en) |=> empty);

endmodule

// File: rtl/cluster_finder_2x2.sv
module cluster_finder_2x2
    import cf_pkg::*;
#(
    parameter int FIFO_DEPTH = CF_FIFO_DEPTH,
    parameter int OVF_W      = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     thr_we,
    input  logic [CF_SW-1:0]         thr_wdata,
    input  logic                     row_valid,
    input  logic                     row_first,
    input  logic [CF_NCOL*CF_AW-1:0] row_data,
    output logic                     row_ready,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [CF_RECW-1:0]       out_data,
    output logic [OVF_W-1:0]         ovf_count
);

    logic [CF_SW-1:0]         thr_q;
    logic [CF_NCOL*CF_AW-1:0] lb_q;
    logic                     lb_valid_q;
    logic [CF_ROWW-1:0]       row_q;
    logic [CF_ROWW-1:0]       row_nx;
    logic [OVF_W-1:0]         ovf_q;

    logic                     accept;
    logic                     kern_en;
    logic [CF_NK*CF_SW-1:0]   k_sums;
    logic [CF_NK-1:0]         k_hits;
    logic                     enc_idle;
    logic                     enc_push;
    cf_rec_t                  enc_rec;
    logic                     f_full;
    logic                     f_empty;
    cf_rec_t                  f_head;
    logic                     drop;

    assign accept  = row_valid && row_ready;
    assign kern_en = !row_first && lb_valid_q;
    assign row_nx  = row_first ? '0 : row_q + CF_ROWW'(1);
    assign drop    = enc_push && f_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '1;
        end else if (thr_we) begin
            thr_q <= thr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lb_q       <= '0;
            lb_valid_q <= 1'b0;
            row_q      <= '0;
        end else if (accept) begin
            lb_q       <= row_data;
            lb_valid_q <= 1'b1;
            row_q      <= row_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= '0;
        end else if (drop && (ovf_q != '1)) begin
            ovf_q <= ovf_q + OVF_W'(1);
        end
    end

    cf_kernel_array u_kern (
        .cur_row  (row_data),
        .prev_row (lb_q),
        .thr      (thr_q),
        .en       (kern_en),
        .sums     (k_sums),
        .hits     (k_hits)
    );

    cf_sparse_enc u_enc (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .hits_in (k_hits),
        .sums_in (k_sums),
        .row_in  (row_nx),
        .idle    (enc_idle),
        .push    (enc_push),
        .rec     (enc_rec)
    );

    cf_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (enc_push),
        .wr_data (enc_rec),
        .full    (f_full),
        .rd_en   (out_ready),
        .rd_data (f_head),
        .empty   (f_empty)
    );

    assign row_ready = enc_idle;
    assign out_valid = !f_empty;
    assign out_data  = f_head;
    assign ovf_count = ovf_q;

    // R1: a frame-start row never starts serialisation
    p_first_row_silent_r1: assert property (@(posedge clk) disable iff (rst)
        (accept && row_first) |=> row_ready);

    // R6: the drop counter moves only on a discarded record
    p_ovf_only_on_drop_r6: assert property (@(posedge clk) disable iff (rst)
        !drop |=> $stable(ovf_count));

    // R5: threshold holds without a write
    p_thr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !thr_we |=> $stable(thr_q));

    // R9: an unaccepted offer leaves the prior row and row number alone
    p_offer_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(lb_q) && $stable(row_q)));

endmodule

// File: tb/cluster_finder_2x2_bench.sv
`timescale 1ns/1ps
module cluster_finder_2x2_bench;
    import cf_pkg::*;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     thr_we = 1'b0;
    logic [CF_SW-1:0]         thr_wdata = '0;
    logic                     row_valid = 1'b0;
    logic                     row_first = 1'b0;
    logic [CF_NCOL*CF_AW-1:0] row_data = '0;
    logic                     row_ready;
    logic                     out_valid;
    logic                     out_ready = 1'b0;
    logic [CF_RECW-1:0]       out_data;
    logic [15:0]              ovf_count;

    always #2.5 clk = ~clk;

    cluster_finder_2x2 u_cluster_finder_2x2 (
        .clk(clk), .rst(rst), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .row_valid(row_valid), .row_first(row_first), .row_data(row_data),
        .row_ready(row_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .ovf_count(ovf_count)
    );

    int total = 0;
    int bad   = 0;

    int cur_b  [CF_NCOL];
    int prev_b [CF_NCOL];
    int pv_m   = 0;
    int row_m  = 0;
    int thr_m  = 127;
    int ovf_m  = 0;
    int exp_col [CF_NK];
    int exp_sum [CF_NK];
    int nexp;

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_thr(input int v);
        @(negedge clk);
        thr_we = 1'b1; thr_wdata = CF_SW'(v);
        @(negedge clk);
        thr_we = 1'b0;
        thr_m = v;
    endtask

    task automatic do_row(input bit first, input bit inject);
        logic [CF_NCOL*CF_AW-1:0] packed_row;
        int lowcnt, kept, got, guard;
        logic [CF_RECW-1:0] expv;
        for (int c = 0; c < CF_NCOL; c++) packed_row[c*CF_AW +: CF_AW] = CF_AW'(cur_b[c]);
        // model
        nexp = 0;
        if (!first && pv_m != 0) begin
            for (int c = 0; c < CF_NK; c++) begin
                int s;
                s = cur_b[c] + cur_b[c+1] + prev_b[c] + prev_b[c+1];
                if (s >= thr_m) begin
                    exp_col[nexp] = c; exp_sum[nexp] = s; nexp++;
                end
            end
        end
        row_m = first ? 0 : (row_m + 1) % 1024;
        for (int c = 0; c < CF_NCOL; c++) prev_b[c] = cur_b[c];
        pv_m = 1;
        kept = (nexp > CF_FIFO_DEPTH) ? CF_FIFO_DEPTH : nexp;
        ovf_m = ovf_m + (nexp - kept);
        if (ovf_m > 65535) ovf_m = 65535;
        // drive
        @(negedge clk);
        chk("R4 ready before row", row_ready, 1);
        row_valid = 1'b1; row_first = first; row_data = packed_row;
        @(negedge clk);
        row_valid = 1'b0; row_first = 1'b0;
        if (inject && nexp >= 2) begin
            row_valid = 1'b1; row_first = 1'b1; row_data = ~packed_row;
        end
        lowcnt = 0; guard = 0;
        while (!row_ready && guard < 400) begin
            lowcnt++; guard++;
            @(negedge clk);
            row_valid = 1'b0; row_first = 1'b0;
        end
        row_valid = 1'b0; row_first = 1'b0;
        chk("R4 busy cycles", lowcnt, nexp);
        got = 0;
        while (out_valid && got < CF_FIFO_DEPTH + 2) begin
            expv = {CF_ROWW'(row_m), CF_CW'(exp_col[got]), CF_SW'(exp_sum[got])};
            chk("R2 R3 record", out_data, expv);
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            got++;
        end
        chk("R7 record count", got, kept);
        chk("R7 empty after drain", out_valid, 0);
        chk("R6 drop count", ovf_count, ovf_m);
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 row_ready", row_ready, 1);
        chk("R10 out_valid", out_valid, 0);
        chk("R10 ovf_count", ovf_count, 0);

        // R1: first row after reset, no flag, produces nothing
        for (int c = 0; c < CF_NCOL; c++) cur_b[c] = 31;
        do_row(0, 0);
        // R5: reset threshold 127 blocks a 124 sum
        do_row(0, 0);
        // R6: all positions hit, overflow
        set_thr(124);
        do_row(0, 0);
        // R1: frame restart silences even with threshold low
        set_thr(0);
        for (int c = 0; c < CF_NCOL; c++) cur_b[c] = (c * 7) % 32;
        do_row(1, 0);

        // R2 R5: threshold sweep over patterned rows
        for (int t = 0; t <= 124; t += 4) begin
            set_thr(t);
            for (int c = 0; c < CF_NCOL; c++) cur_b[c] = (t * 3 + c * c * 5 + c) % 32;
            do_row(0, 0);
        end
        // exact-threshold boundary: sum equal and one below
        for (int c = 0; c < CF_NCOL; c++) cur_b[c] = 10;
        do_row(0, 0);
        set_thr(40);
        do_row(0, 0);
        set_thr(41);
        do_row(0, 0);

        // R9: offer during busy row is ignored
        set_thr(60);
        for (int c = 0; c < CF_NCOL; c++) cur_b[c] = (c % 5 == 0) ? 31 : 2;
        do_row(0, 1);
        for (int c = 0; c < CF_NCOL; c++) cur_b[c] = (c % 3 == 0) ? 30 : 1;
        do_row(0, 0);

        // R8: row number wrap
        set_thr(127);
        for (int c = 0; c < CF_NCOL; c++) cur_b[c] = 0;
        do_row(1, 0);
        for (int i = 0; i < 1030; i++) do_row(0, 0);
        set_thr(0);
        for (int c = 0; c < CF_NCOL; c++) cur_b[c] = (c < 3) ? 31 : 0;
        do_row(0, 0);
        chk("R8 row wrapped", row_m, 7);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule